// File: doc/BRIEF.md
# Two-Bank SDR SDRAM Controller with Power-Up Sequencer

This block drives a two-bank single-data-rate SDRAM from one clock. It leaves reset in a quiet phase. During that phase it drives only no-operation commands and holds the data mask high. It then runs the start-up order: close all banks, refresh at least twice, and load the mode register. After that it serves one user request at a time. Each request carries a bank, a row, a column, a data word and a one-bit write mask.

Every access uses a closed-page policy. The block opens the row, waits the row-to-column delay, and issues the column command with auto-precharge set. The next row open waits the full row cycle. A free-running interval counter raises a refresh demand, and that demand outranks user requests. To serve it, the block issues a precharge-all and then an auto-refresh. Read data comes back on a one-cycle valid strobe, at a fixed latency after the read command.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held, the command pins read no-operation ({ras_n,cas_n,we_n} = 3'b111), DQM is high and `req_ready` is low.
- R2: After reset the block drives only no-operation for at least INIT_CYCLES clocks. The first other command is a precharge with address bit 9 high (all banks).
- R3: Before the mode register is loaded, at least INIT_REFS auto-refresh commands are issued. A refresh is followed by no row open for T_RC clocks.
- R4: The mode register set carries the word 0x220: burst length code 3'b000 in bits 2..0, sequential type (0) in bit 3, CAS latency 2 (3'b010) in bits 6..4, and single-location writes (1) in bit 9. No row open follows it within 2 clocks. DQM is low once requests are accepted.
- R5: Commands use the {ras_n,cas_n,we_n} codes 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 111 no-op. Burst terminate (110) is never issued.
- R6: A read or write comes at least T_RCD clocks after the activate. It carries address bit 9 high (auto-precharge), the column in bits 7..0, and the request's bank on `sd_ba` (0 = bank A, 1 = bank B).
- R7: Two activates are at least T_RC clocks apart.
- R8: Write data and the output enable appear in the same cycle as the write command. `sd_dqm` equals the request's mask bit in that cycle, so a masked write leaves memory unchanged.
- R9: `rd_valid` pulses for one cycle, CAS_LAT+1 clocks after the read command appears on the pins. It carries the word the memory returned.
- R10: A refresh demand arises every REFRESH_INTERVAL clocks. It is served by a precharge-all, followed T_RP or more clocks later by an auto-refresh.
- R11: A pending refresh is served ahead of waiting requests. Under continuous request load, refreshes stay within a few clocks of the refresh interval.
- R12: `req_ready` is high only when the block is idle. It is low in the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | 1 | 1 suppresses the write |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Returned read data |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | DATA_W | Data driven toward memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Data returned by memory |

## Verification
The assertions watch the pins on every cycle. They check that no command leaves the block during the quiet phase after reset. They check the row-to-column and row-to-row spacings, and that auto-precharge is set on every column command. They also check that the bus is driven only on writes, that DQM is low when requests are accepted, and that the read strobe lands exactly one latency after a read. The bench scenarios cover the rest. A memory model checks the start-up order and the mode word. Data round trips show masked writes and bank separation. A long request stream shows that refresh still arrives on time under load.

// File: rtl/sdram_ctrl_pkg.sv
// Shared encodings for the SDRAM controller.
// Assumes the command is carried on {ras_n, cas_n, we_n} in that bit order.
package sdram_ctrl_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PWR_WAIT,
        ST_INIT_REF,
        ST_INIT_MRS,
        ST_IDLE,
        ST_COLUMN,
        ST_REFRESH
    } ctrl_state_e;

endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that enforces the minimum spacing before the next command.
// Loading N-1 with a command lets the next command issue N clocks later.
// Assumes load values never exceed the counter width.
module sdram_gap_timer #(
    parameter int CNT_W = 16,
    parameter int START = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Count down to zero, reload on each issued command.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= CNT_W'(START);
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_tick.sv
// Free-running refresh interval counter with a sticky demand flag.
// Assumes the consumer pulses ack when it issues the refresh.
module sdram_refresh_tick #(
    parameter int INTERVAL = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(INTERVAL - 1));

    // Interval counter wraps every INTERVAL clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Demand is set on each tick and cleared by service, tick wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (tick) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end
endmodule

// File: rtl/sdram_read_return.sv
// Tracks an issued read through the command register and CAS latency,
// then captures the memory data and pulses the valid strobe.
// Assumes rd_issue is high in the cycle before the read reaches the pins.
module sdram_read_return #(
    parameter int CAS_LAT = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT:0] stage;

    // Delay line aligned with the command register and latency.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[CAS_LAT-1:0], rd_issue};
    end

    // Capture the returned word when the tracked read arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= stage[CAS_LAT];
            if (stage[CAS_LAT]) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_ctrl.sv
// Two-bank SDR SDRAM controller: power-up sequencing, closed-page
// accesses with auto-precharge, and refresh with priority over requests.
// Assumes one clock for controller and memory, one request in flight,
// burst length one, and that row and column widths cover address bit 9.
module sdram_ctrl #(
    parameter int ROW_W            = 11,
    parameter int COL_W            = 8,
    parameter int DATA_W           = 32,
    parameter int INIT_CYCLES      = 20000,
    parameter int INIT_REFS        = 2,
    parameter int REFRESH_INTERVAL = 625,
    parameter int CAS_LAT          = 2,
    parameter int T_RC             = 7,
    parameter int T_RAS            = 5,
    parameter int T_RP             = 2,
    parameter int T_RCD            = 2,
    parameter int T_RDL            = 2,
    parameter int T_MRD            = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    import sdram_ctrl_pkg::*;

    localparam int AP_BIT   = 9;
    localparam int GAP_A    = T_RAS + T_RP;
    localparam int GAP_B    = T_RCD + T_RDL + T_RP;
    localparam int GAP_AB   = (GAP_A > GAP_B) ? GAP_A : GAP_B;
    localparam int ACT_GAP  = (T_RC > GAP_AB) ? T_RC : GAP_AB;
    localparam int POST_RW  = ACT_GAP - T_RCD;
    localparam int CNT_W    = $clog2(INIT_CYCLES + ACT_GAP + 2);
    localparam int REF_CW   = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] MODE_WORD =
        ROW_W'((CAS_LAT << 4) | (1 << AP_BIT));
    localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1 << AP_BIT);

    ctrl_state_e        state, nxt_state;
    sd_cmd_e            issue;
    logic [ROW_W-1:0]   iss_addr;
    logic               iss_ba;
    logic               tmr_load, tmr_done;
    logic [CNT_W-1:0]   tmr_val;
    logic               ref_pend, ref_ack, accept, rd_issue, wr_issue;
    logic [REF_CW-1:0]  init_refs;
    logic               hold_we, hold_bank, hold_mask;
    logic [COL_W-1:0]   hold_col;
    logic [DATA_W-1:0]  hold_wdata;
    logic               init_next;

    sdram_gap_timer #(.CNT_W(CNT_W), .START(INIT_CYCLES)) i_gap (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .done(tmr_done)
    );

    sdram_refresh_tick #(.INTERVAL(REFRESH_INTERVAL)) i_tick (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend)
    );

    sdram_read_return #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) i_ret (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue),
        .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign req_ready = (state == ST_IDLE) && tmr_done && !ref_pend;
    assign init_next = (nxt_state == ST_PWR_WAIT) || (nxt_state == ST_INIT_REF)
                    || (nxt_state == ST_INIT_MRS);

    // Choose the command for this cycle and the spacing that follows it.
    always_comb begin
        nxt_state = state;
        issue     = CMD_NOP;
        iss_addr  = '0;
        iss_ba    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ref_ack   = 1'b0;
        accept    = 1'b0;
        rd_issue  = 1'b0;
        wr_issue  = 1'b0;
        if (tmr_done) begin
            case (state)
                ST_PWR_WAIT: begin
                    issue = CMD_PRE; iss_addr = AP_MASK;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1);
                    nxt_state = ST_INIT_REF;
                end
                ST_INIT_REF: begin
                    issue = CMD_REF;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_RC - 1);
                    if (init_refs == REF_CW'(INIT_REFS - 1)) nxt_state = ST_INIT_MRS;
                end
                ST_INIT_MRS: begin
                    issue = CMD_MRS; iss_addr = MODE_WORD;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD - 1);
                    nxt_state = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        issue = CMD_PRE; iss_addr = AP_MASK;
                        tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1);
                        nxt_state = ST_REFRESH;
                    end else if (req_valid) begin
                        issue = CMD_ACT; iss_addr = req_row; iss_ba = req_bank;
                        accept = 1'b1;
                        tmr_load = 1'b1; tmr_val = CNT_W'(T_RCD - 1);
                        nxt_state = ST_COLUMN;
                    end
                end
                ST_COLUMN: begin
                    issue    = hold_we ? CMD_WR : CMD_RD;
                    iss_addr = ROW_W'(hold_col) | AP_MASK;
                    iss_ba   = hold_bank;
                    rd_issue = !hold_we;
                    wr_issue = hold_we;
                    tmr_load = 1'b1; tmr_val = CNT_W'(POST_RW - 1);
                    nxt_state = ST_IDLE;
                end
                ST_REFRESH: begin
                    issue = CMD_REF; ref_ack = 1'b1;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_RC - 1);
                    nxt_state = ST_IDLE;
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // State register and count of start-up refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PWR_WAIT;
            init_refs <= '0;
        end else begin
            state <= nxt_state;
            if (state == ST_INIT_REF && tmr_done) init_refs <= init_refs + 1'b1;
        end
    end

    // Hold the accepted request for the column phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_we <= 1'b0; hold_bank <= 1'b0; hold_mask <= 1'b0;
            hold_col <= '0; hold_wdata <= '0;
        end else if (accept) begin
            hold_we <= req_write; hold_bank <= req_bank; hold_mask <= req_mask;
            hold_col <= req_col; hold_wdata <= req_wdata;
        end
    end

    // Registered memory pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
            sd_ba     <= 1'b0;
            sd_addr   <= '0;
            sd_dqm    <= 1'b1;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
        end else begin
            {sd_ras_n, sd_cas_n, sd_we_n} <= issue;
            sd_ba     <= iss_ba;
            sd_addr   <= iss_addr;
            sd_dqm    <= init_next ? 1'b1 : (wr_issue & hold_mask);
            sd_dq_out <= wr_issue ? hold_wdata : '0;
            sd_dq_oe  <= wr_issue;
        end
    end
endmodule

// File: rtl/sdram_ctrl_checker.sv
// Pin-level timing checks for sdram_ctrl, attached by bind.
// Assumes the command is read as {ras_n, cas_n, we_n}.
module sdram_ctrl_checker #(
    parameter int ROW_W       = 11,
    parameter int INIT_CYCLES = 20000,
    parameter int CAS_LAT     = 2,
    parameter int T_RC        = 7,
    parameter int T_RCD       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             sd_dqm,
    input logic             sd_dq_oe
);
    import sdram_ctrl_pkg::*;

    logic [2:0]  cmd;
    logic [31:0] pwr_cnt;
    logic [7:0]  since_act;
    logic        col_cmd;

    assign cmd     = {sd_ras_n, sd_cas_n, sd_we_n};
    assign col_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);

    // Clocks since reset, saturating at the quiet period.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pwr_cnt <= '0;
        else if (pwr_cnt < INIT_CYCLES) pwr_cnt <= pwr_cnt + 1;
    end

    // Clocks since the last activate seen on the pins, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_act <= 8'hff;
        else if (cmd == CMD_ACT)   since_act <= 8'd1;
        else if (since_act != 8'hff) since_act <= since_act + 1'b1;
    end

    a_r2_quiet_power_up: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cnt < INIT_CYCLES) |-> (cmd == CMD_NOP));
    a_r6_rcd_met: assert property (@(posedge clk) disable iff (!rst_n)
        col_cmd |-> (since_act >= 8'(T_RCD)));
    a_r6_auto_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        col_cmd |-> sd_addr[9]);
    a_r7_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_act >= 8'(T_RC)));
    a_r8_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == CMD_WR));
    a_r9_return_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd == CMD_RD, CAS_LAT + 1));
    a_r4_dqm_low_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sd_dqm);
    a_r5_no_terminate: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != CMD_BST);
endmodule

bind sdram_ctrl sdram_ctrl_checker #(
    .ROW_W(ROW_W), .INIT_CYCLES(INIT_CYCLES), .CAS_LAT(CAS_LAT),
    .T_RC(T_RC), .T_RCD(T_RCD)
) i_sdram_ctrl_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_oe(sd_dq_oe)
);

// File: tb/test_sdram_ctrl.sv
// Directed bench with a behavioural two-bank memory that checks command
// order and spacing at the pins.
module test_sdram_ctrl;
    import sdram_ctrl_pkg::*;

    localparam int ROW_W = 11, COL_W = 8, DATA_W = 32;
    localparam int INIT_CYCLES = 20000, REF_INT = 625, CL = 2;
    localparam int T_RC = 7, T_RP = 2, T_RCD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0, req_mask = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rd_valid, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dqm, sd_dq_oe;
    logic [DATA_W-1:0] rd_data, sd_dq_out;
    logic [DATA_W-1:0] sd_dq_in = '0;
    logic [ROW_W-1:0] sd_addr;

    always #10 clk = ~clk;

    sdram_ctrl i_sdram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    int n_checks = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Memory model state
    int cyc = 0, rst_cyc = -1;
    int last_act = -1000, last_pre = -1000, last_ref = -1000, last_mrs = -1000, last_rd = -1000;
    bit first_seen = 0, mrs_seen = 0;
    int init_refs = 0;
    int ref_prev = -1, gap_min = 1000000, gap_max = 0, n_gaps = 0;
    logic [ROW_W-1:0] open_row [2];
    logic [DATA_W-1:0] mem [bit [19:0]];
    logic [DATA_W-1:0] rstage [CL+1];
    logic [2:0] cmd;
    assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

    // Decode the registered pins between edges and check spacings.
    always @(negedge clk) begin
        bit [19:0] key;
        cyc++;
        if (rst_n && rst_cyc < 0) rst_cyc = cyc;
        for (int i = CL; i > 0; i--) rstage[i] = rstage[i-1];
        rstage[0] = '0;
        if (rst_n && cmd != CMD_NOP) begin
            if (!first_seen) begin
                chk(cmd == CMD_PRE && sd_addr[9], "R2 first command precharge-all", cmd, CMD_PRE);
                chk(cyc - rst_cyc >= INIT_CYCLES, "R2 quiet period", cyc - rst_cyc, INIT_CYCLES);
                first_seen = 1;
            end
            key = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
            case (cmd)
                CMD_PRE: last_pre = cyc;
                CMD_REF: begin
                    chk(cyc - last_pre >= T_RP, "R10 precharge to refresh", cyc - last_pre, T_RP);
                    if (!mrs_seen) init_refs++;
                    else begin
                        if (ref_prev >= 0) begin
                            n_gaps++;
                            if (cyc - ref_prev < gap_min) gap_min = cyc - ref_prev;
                            if (cyc - ref_prev > gap_max) gap_max = cyc - ref_prev;
                        end
                        ref_prev = cyc;
                    end
                    last_ref = cyc;
                end
                CMD_MRS: begin
                    chk(init_refs >= 2, "R3 refreshes before mode set", init_refs, 2);
                    chk(sd_addr == 11'h220, "R4 mode word", sd_addr, 11'h220);
                    mrs_seen = 1; last_mrs = cyc;
                end
                CMD_ACT: begin
                    chk(mrs_seen, "R4 activate after mode set", mrs_seen, 1);
                    chk(cyc - last_mrs >= 2, "R4 mode set to activate", cyc - last_mrs, 2);
                    chk(cyc - last_act >= T_RC, "R7 activate spacing", cyc - last_act, T_RC);
                    chk(cyc - last_ref >= T_RC, "R3 refresh to activate", cyc - last_ref, T_RC);
                    open_row[sd_ba] = sd_addr;
                    last_act = cyc;
                end
                CMD_WR: begin
                    chk(cyc - last_act >= T_RCD, "R6 activate to write", cyc - last_act, T_RCD);
                    chk(sd_addr[9], "R6 write auto-precharge", sd_addr[9], 1);
                    chk(sd_dq_oe, "R8 data driven with write", sd_dq_oe, 1);
                    if (!sd_dqm) mem[key] = sd_dq_out;
                end
                CMD_RD: begin
                    chk(cyc - last_act >= T_RCD, "R6 activate to read", cyc - last_act, T_RCD);
                    chk(sd_addr[9], "R6 read auto-precharge", sd_addr[9], 1);
                    rstage[0] = mem.exists(key) ? mem[key] : '0;
                    last_rd = cyc;
                end
                default: chk(0, "R5 unexpected command code", cmd, CMD_NOP);
            endcase
        end
        sd_dq_in = rstage[CL];
    end

    task automatic do_req(input bit we, input bit bank, input logic [ROW_W-1:0] row,
                          input logic [COL_W-1:0] col, input logic [DATA_W-1:0] data,
                          input bit mask);
        bit acc;
        @(negedge clk); #1;
        req_valid = 1; req_write = we; req_bank = bank; req_row = row;
        req_col = col; req_wdata = data; req_mask = mask;
        forever begin
            acc = req_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        req_valid = 0;
        chk(!req_ready, "R12 not ready after accept", req_ready, 0);
    endtask

    task automatic do_read(input bit bank, input logic [ROW_W-1:0] row,
                           input logic [COL_W-1:0] col, output logic [DATA_W-1:0] q,
                           output int lat);
        do_req(0, bank, row, col, '0, 0);
        q = 'x; lat = -1;
        for (int i = 0; i < 40; i++) begin
            if (rd_valid) begin q = rd_data; lat = cyc - last_rd; break; end
            @(negedge clk); #1;
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (4) @(negedge clk);
        #1;
        chk(cmd == CMD_NOP, "R1 reset command", cmd, CMD_NOP);
        chk(sd_dqm == 1'b1, "R1 reset dqm", sd_dqm, 1);
        chk(req_ready == 1'b0, "R1 reset ready", req_ready, 0);
        rst_n = 1;
    endtask

    task automatic t_init();
        int n = 0;
        while (!req_ready && n < INIT_CYCLES + 200) begin @(negedge clk); #1; n++; end
        chk(req_ready, "R2 start-up completes", req_ready, 1);
        chk(init_refs >= 2, "R3 start-up refresh count", init_refs, 2);
        chk(mrs_seen, "R4 mode register loaded", mrs_seen, 1);
        chk(sd_dqm == 1'b0, "R4 dqm released", sd_dqm, 0);
    endtask

    task automatic t_write_read();
        logic [DATA_W-1:0] q; int lat;
        do_req(1, 0, 11'd5, 8'd3, 32'hA5A5_0001, 0);
        do_read(0, 11'd5, 8'd3, q, lat);
        chk(q == 32'hA5A5_0001, "R8 write then read data", q, 32'hA5A5_0001);
        chk(lat == CL + 1, "R9 read return latency", lat, CL + 1);
    endtask

    task automatic t_masked_write();
        logic [DATA_W-1:0] q; int lat;
        do_req(1, 0, 11'd5, 8'd3, 32'h0BAD_0BAD, 1);
        do_read(0, 11'd5, 8'd3, q, lat);
        chk(q == 32'hA5A5_0001, "R8 masked write ignored", q, 32'hA5A5_0001);
    endtask

    task automatic t_bank_select();
        logic [DATA_W-1:0] q; int lat;
        do_req(1, 1, 11'd5, 8'd3, 32'hC0DE_B00B, 0);
        do_read(1, 11'd5, 8'd3, q, lat);
        chk(q == 32'hC0DE_B00B, "R6 bank B data", q, 32'hC0DE_B00B);
        do_read(0, 11'd5, 8'd3, q, lat);
        chk(q == 32'hA5A5_0001, "R6 bank A untouched", q, 32'hA5A5_0001);
        do_req(1, 1, 11'h7FF, 8'hFF, 32'hFFFF_0000, 0);
        do_read(1, 11'h7FF, 8'hFF, q, lat);
        chk(q == 32'hFFFF_0000, "R6 top row and column", q, 32'hFFFF_0000);
        chk(lat == CL + 1, "R9 latency on bank B", lat, CL + 1);
    endtask

    task automatic t_refresh_under_load();
        logic [DATA_W-1:0] q; int lat;
        ref_prev = -1; gap_min = 1000000; gap_max = 0; n_gaps = 0;
        for (int i = 0; i < 220; i++)
            do_req(1, i[0], ROW_W'(i), COL_W'(i * 3), 32'h1000_0000 + i, 0);
        chk(n_gaps >= 1, "R10 refreshes seen under load", n_gaps, 1);
        chk(gap_max <= REF_INT + 16, "R11 refresh not starved", gap_max, REF_INT);
        chk(gap_min >= REF_INT - 16, "R10 refresh interval", gap_min, REF_INT);
        do_read(1, ROW_W'(101), COL_W'(303), q, lat);
        chk(q == 32'h1000_0000 + 101, "R11 data intact across refresh", q, 32'h1000_0065);
    endtask

    initial begin
        t_reset();
        t_init();
        t_write_read();
        t_masked_write();
        t_bank_select();
        t_refresh_under_load();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule